// File: doc/BRIEF.md
# Keyed-Sequence Watchdog Timer

This block is a watchdog for an 8-bit microcontroller core. It listens on the core's special-function-register write bus and has two write-only registers. One is a key register at address 0xA6, which both starts the watchdog and services it. The other is a timeout-select register at address 0xA7. Nothing in the block can be read back.

While it runs, a machine-cycle strobe from the oscillator domain drives a prescaler. The prescaler in turn advances a counter. If software fails to write the two-byte key pattern in time, the counter reaches its top value. The block then raises an active-high reset output for a fixed number of oscillator periods.

The SFR write bus is a plain single-cycle strobe. Every write is taken in the cycle it is presented, with no back-pressure, so there is no ready signal. The reset output is a plain level.

Top module: `kwdt_top`

## Requirements
- R1: After reset the watchdog is off, `wdt_rst` is low, and the timeout select is 0. With no enabling sequence, `wdt_rst` stays low however many strobes arrive.
- R2: A write of 0x1E to address 0xA6, followed by a write of 0xE1 to 0xA6 with no other write to 0xA6 between them, turns the watchdog on. Its counter and prescaler start from zero.
- R3: Once on, the watchdog is turned off only by `rst_n` or by its own overflow. Writes of other values to 0xA6, or any writes to 0xA7, never stop it.
- R4: The counter is `CNT_W` bits wide (14 by default). The reset pulse starts on the edge that samples the advance taking the counter to 2^CNT_W−1. With select S, this is the edge of the (2^CNT_W−1)·2^S-th strobe after enabling.
- R5: Bits 2:0 of a write to 0xA7 set the select S. The counter then advances once every 2^S strobes. Bits 7:3 of that write are ignored.
- R6: Repeating the key sequence while the watchdog runs clears the counter and the prescaler. The next overflow then comes a full timeout after the service write.
- R7: A 0xE1 write to 0xA6 that does not directly follow a 0x1E write to 0xA6 does nothing. Any other value written to 0xA6 cancels a pending 0x1E. Writes to other addresses leave a pending 0x1E intact.
- R8: On overflow, `wdt_rst` is high for exactly `PULSE_LEN` clock cycles (96 by default). It then returns low.
- R9: Overflow turns the watchdog off and clears the counter and the prescaler. A key sequence written while the pulse is high is ignored, so no further pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low hardware reset |
| mc_tick | input | 1 | One-cycle machine-cycle strobe |
| sfr_wr | input | 1 | SFR write strobe |
| sfr_addr | input | 8 | SFR write address |
| sfr_wdata | input | 8 | SFR write data |
| wdt_rst | output | 1 | Active-high reset pulse |

## Verification
The hardest state to reach from the ports is a key sequence arriving while the reset pulse is high. Getting there requires a full timeout first. The bench builds the block with a narrow counter so that a timeout takes only a few hundred strobes. It writes the key while the pulse is high, then watches for longer than a full timeout to show that no second pulse comes. The exact overflow point is checked by counting the strobes the bench itself drives from the write that arms the watchdog to the rising edge of the pulse.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
  localparam logic [7:0] ADDR_KEY = 8'hA6;
  localparam logic [7:0] ADDR_SEL = 8'hA7;
  localparam logic [7:0] KEY_FIRST = 8'h1E;
  localparam logic [7:0] KEY_SECOND = 8'hE1;

  typedef struct packed {
    logic       wr;
    logic [7:0] addr;
    logic [7:0] data;
  } sfr_wr_t;

  typedef enum logic {
    SEQ_IDLE,
    SEQ_ARMED
  } seq_state_e;
endpackage

// File: rtl/kwdt_regs.sv
module kwdt_regs
  import kwdt_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  sfr_wr_t          bus,
  input  logic             block,
  output logic             key_ok,
  output logic [SEL_W-1:0] sel
);
  seq_state_e state_q;
  logic       hit_key;
  logic       hit_sel;

  assign hit_key = bus.wr && (bus.addr == ADDR_KEY);
  assign hit_sel = bus.wr && (bus.addr == ADDR_SEL);

  // second key byte completes the sequence only straight after the first
  assign key_ok = hit_key && (bus.data == KEY_SECOND) &&
                  (state_q == SEQ_ARMED) && !block;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      sel     <= '0;
    end else begin
      if (hit_sel) sel <= bus.data[SEL_W-1:0];
      if (hit_key) begin
        if (!block && bus.data == KEY_FIRST) state_q <= SEQ_ARMED;
        else                                 state_q <= SEQ_IDLE;
      end
    end
  end
endmodule

// File: rtl/kwdt_count.sv
module kwdt_count #(
  parameter int CNT_W = 14,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mc_tick,
  input  logic             key_ok,
  input  logic [SEL_W-1:0] sel,
  output logic             en,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf
);
  localparam int PRE_W = (1 << SEL_W) - 1;
  localparam logic [CNT_W-1:0] CNT_LAST = {{(CNT_W-1){1'b1}}, 1'b0};

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;
  logic             adv;

  // low S bits of the prescaler must be all ones for an advance
  for (genvar i = 0; i < PRE_W; i++) begin : g_mask
    assign mask[i] = (i < int'(sel));
  end

  assign adv = en && mc_tick && ((pre_q & mask) == mask);
  assign ovf = adv && (cnt == CNT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en    <= 1'b0;
      cnt   <= '0;
      pre_q <= '0;
    end else if (ovf) begin
      en    <= 1'b0;
      cnt   <= '0;
      pre_q <= '0;
    end else if (key_ok) begin
      en    <= 1'b1;
      cnt   <= '0;
      pre_q <= '0;
    end else if (en && mc_tick) begin
      pre_q <= pre_q + 1'b1;
      if (adv) cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/kwdt_pulse.sv
module kwdt_pulse #(
  parameter int PULSE_LEN = 96
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic busy
);
  localparam int PW = $clog2(PULSE_LEN);
  logic [PW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      left_q <= '0;
    end else if (busy) begin
      if (left_q == '0) busy <= 1'b0;
      else              left_q <= left_q - 1'b1;
    end else if (fire) begin
      busy   <= 1'b1;
      left_q <= PW'(PULSE_LEN - 1);
    end
  end
endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
  import kwdt_pkg::*;
#(
  parameter int CNT_W     = 14,
  parameter int SEL_W     = 3,
  parameter int PULSE_LEN = 96
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mc_tick,
  input  logic       sfr_wr,
  input  logic [7:0] sfr_addr,
  input  logic [7:0] sfr_wdata,
  output logic       wdt_rst
);
  sfr_wr_t          bus;
  logic             key_ok;
  logic [SEL_W-1:0] sel;
  logic             en_q;
  logic [CNT_W-1:0] cnt_q;
  logic             ovf;

  assign bus = '{wr: sfr_wr, addr: sfr_addr, data: sfr_wdata};

  kwdt_regs #(.SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus(bus), .block(wdt_rst),
    .key_ok(key_ok), .sel(sel)
  );

  kwdt_count #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_count (
    .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick), .key_ok(key_ok),
    .sel(sel), .en(en_q), .cnt(cnt_q), .ovf(ovf)
  );

  kwdt_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk(clk), .rst_n(rst_n), .fire(ovf), .busy(wdt_rst)
  );
endmodule

// File: rtl/kwdt_chk.sv
module kwdt_chk
  import kwdt_pkg::*;
#(
  parameter int CNT_W     = 14,
  parameter int PULSE_LEN = 96
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sfr_wr,
  input logic [7:0]       sfr_addr,
  input logic [7:0]       sfr_wdata,
  input logic             wdt_rst,
  input logic             en,
  input logic [CNT_W-1:0] cnt
);
  localparam int HW = $clog2(PULSE_LEN + 1) + 1;
  localparam logic [CNT_W-1:0] CNT_LAST = {{(CNT_W-1){1'b1}}, 1'b0};
  logic [HW-1:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hi_cnt <= '0;
    else if (wdt_rst) hi_cnt <= hi_cnt + 1'b1;
    else              hi_cnt <= '0;
  end

  p_en_needs_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en) |-> $past(sfr_wr && sfr_addr == ADDR_KEY && sfr_wdata == KEY_SECOND));

  p_off_only_by_ovf_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en) |-> $rose(wdt_rst));

  p_rise_at_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_rst) |-> $past(cnt) == CNT_LAST);

  p_cnt_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != $past(cnt)) |-> (cnt == CNT_W'($past(cnt) + 1'b1) || cnt == '0));

  p_pulse_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wdt_rst) |-> hi_cnt == HW'(PULSE_LEN));

  p_pulse_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hi_cnt <= HW'(PULSE_LEN));

  p_off_in_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |-> !en);
endmodule

bind kwdt_top kwdt_chk #(.CNT_W(CNT_W), .PULSE_LEN(PULSE_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .sfr_wr(sfr_wr), .sfr_addr(sfr_addr),
  .sfr_wdata(sfr_wdata), .wdt_rst(wdt_rst), .en(en_q), .cnt(cnt_q)
);

// File: tb/kwdt_top_bench.sv
module kwdt_top_bench;
  localparam int CNT_W = 6;
  localparam int PULSE_LEN = 96;
  localparam int MC_DIV = 12;
  localparam int TOP = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mc_tick = 1'b0;
  logic sfr_wr = 1'b0;
  logic [7:0] sfr_addr = '0;
  logic [7:0] sfr_wdata = '0;
  logic wdt_rst;

  int total = 0;
  int bad = 0;
  int tick_cnt = 0;
  int div_cnt = 0;
  int cycles = 0;
  bit done = 1'b0;

  kwdt_top #(.CNT_W(CNT_W), .SEL_W(3), .PULSE_LEN(PULSE_LEN)) u_kwdt_top (
    .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick), .sfr_wr(sfr_wr),
    .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata), .wdt_rst(wdt_rst)
  );

  always #4 clk = ~clk;

  always @(negedge clk) begin
    div_cnt <= (div_cnt == MC_DIV - 1) ? 0 : div_cnt + 1;
    mc_tick <= (div_cnt == 0);
  end

  always @(posedge clk) begin
    if (mc_tick) tick_cnt <= tick_cnt + 1;
    cycles <= cycles + 1;
  end

  always @(posedge clk) begin
    if (cycles == 190000 && !done) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: run hung, act=%0d exp=<190000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total = total + 1;
    if (act != exp) begin
      bad = bad + 1;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    sfr_wr = 1'b1; sfr_addr = a; sfr_wdata = d;
    @(negedge clk);
    sfr_wr = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic key(output int mark);
    wr(8'hA6, 8'h1E);
    wr(8'hA6, 8'hE1);
    mark = tick_cnt;
  endtask

  // wait for the pulse; return strobes since mark, or -1 if none
  task automatic wait_rise(input int mark, input int max_ticks, output int got);
    got = -1;
    for (int i = 0; i < (max_ticks + 20) * MC_DIV; i++) begin
      if (wdt_rst) begin
        got = tick_cnt - mark;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic pulse_len(output int hi);
    hi = 0;
    while (wdt_rst && hi < 4 * PULSE_LEN) begin
      hi++;
      @(negedge clk);
    end
  endtask

  task automatic quiet(input int ticks, output int highs);
    highs = 0;
    for (int i = 0; i < ticks * MC_DIV; i++) begin
      @(negedge clk);
      if (wdt_rst) highs++;
    end
  endtask

  task automatic t_reset();
    int h;
    chk("R1 reset output", int'(wdt_rst), 0);
    quiet(TOP + 10, h);
    chk("R1 idle without key", h, 0);
  endtask

  task automatic t_enable();
    int m, g, hi, h;
    key(m);
    wait_rise(m, TOP, g);
    chk("R2/R4 strobes to overflow S=0", g, TOP);
    pulse_len(hi);
    chk("R8 pulse length", hi, PULSE_LEN);
    quiet(2 * TOP, h);
    chk("R9 off after overflow", h, 0);
  endtask

  task automatic t_prescale();
    int m, g, hi;
    wr(8'hA7, 8'hF9);
    key(m);
    wait_rise(m, 2 * TOP, g);
    chk("R5 S=1 reserved bits ignored", g, 2 * TOP);
    pulse_len(hi);
    wr(8'hA7, 8'h03);
    key(m);
    wait_rise(m, 8 * TOP, g);
    chk("R5 S=3", g, 8 * TOP);
    pulse_len(hi);
    chk("R8 pulse length S=3", hi, PULSE_LEN);
    wr(8'hA7, 8'h00);
  endtask

  task automatic t_service();
    int m, g, hi, h;
    key(m);
    quiet(TOP - 13, h);
    chk("R6 no pulse before service", h, 0);
    key(m);
    wait_rise(m, TOP, g);
    chk("R6 full timeout after service", g, TOP);
    pulse_len(hi);
  endtask

  task automatic t_bad_seq();
    int m, g, h, hi;
    wr(8'hA6, 8'hE1);
    quiet(TOP + 10, h);
    chk("R7 lone second byte", h, 0);
    wr(8'hA6, 8'h1E);
    wr(8'hA6, 8'h55);
    wr(8'hA6, 8'hE1);
    quiet(TOP + 10, h);
    chk("R7 other value cancels", h, 0);
    wr(8'hA6, 8'h1E);
    wr(8'hA7, 8'h00);
    wr(8'hA6, 8'hE1);
    m = tick_cnt;
    wait_rise(m, TOP, g);
    chk("R7 other address keeps pending byte", g, TOP);
    pulse_len(hi);
  endtask

  task automatic t_no_disable();
    int m, g, h, hi;
    key(m);
    wr(8'hA6, 8'h00);
    wr(8'hA6, 8'hFF);
    wr(8'hA7, 8'h00);
    wait_rise(m, TOP, g);
    chk("R3 writes do not stop it", g, TOP);
    pulse_len(hi);
    key(m);
    quiet(20, h);
    do_reset();
    quiet(TOP + 10, h);
    chk("R3/R1 hardware reset stops it", h, 0);
  endtask

  task automatic t_key_in_pulse();
    int m, g, h, hi;
    key(m);
    wait_rise(m, TOP, g);
    chk("R9 overflow reached", g, TOP);
    wr(8'hA6, 8'h1E);
    wr(8'hA6, 8'hE1);
    pulse_len(hi);
    chk("R9 pulse completes", hi + 4, PULSE_LEN);
    quiet(2 * TOP, h);
    chk("R9 key in pulse ignored", h, 0);
  endtask

  initial begin
    do_reset();
    t_reset();
    t_enable();
    t_prescale();
    t_service();
    t_bad_seq();
    t_no_disable();
    t_key_in_pulse();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule